// File: doc/BRIEF.md
# E3 Trail Trace Overhead Sequencer

This block supplies two overhead bytes to an E3 transmit framer for every outbound frame: the trail trace byte and the maintenance byte. A host port writes a bank of sixteen 8-bit trail identifier entries, a maintenance control byte and a two-bit source select. The framer timing logic sends a one-cycle frame-start pulse. On each pulse the block moves to the next trail entry and loads both output bytes, and they stay unchanged until the next pulse.

The sixteen-frame trail multiframe is counted inside the block. Entry 0 opens each multiframe and the entries follow in ascending order. By convention, entry 0 carries a start marker in its top bit and a CRC-7 that software has already computed. The block sends every entry exactly as written and never checks or changes it. The two alarm bits of the maintenance byte are the far-end error indication (bit 6) and the far-end failure indication (bit 7). Each one comes either from the host copy or from a live input driven by the receive side, and a separate select bit chooses the source for each.

Top module: `e3_trail_overhead`

## Requirements
- R1: After reset, `trByte`, `maByte` and `mfStart` are 0. The first frame-start pulse after reset presents trail entry 0.
- R2: Each frame-start pulse presents the entry that follows the previous one (0, 1, …, 15). After entry 15 the next pulse presents entry 0 again.
- R3: The outputs change only on the clock edge that samples a frame-start pulse, and are readable in the following cycle. With no pulse they hold their values and the entry position does not move.
- R4: Host writes with `hostAddr` 0 to 15 set trail entries 0 to 15. The entries are sent bit for bit, including a top bit of 1 in any entry.
- R5: `mfStart` is 1 exactly while `trByte` holds a byte taken from entry 0.
- R6: A host write to address 16 sets the maintenance control byte. Bits 5 to 0 of `maByte` repeat its bits 5 to 0 as they were at the frame-start pulse.
- R7: A host write to address 17 sets the source select. Data bit 0 selects the source for `maByte` bit 6 and data bit 1 selects the source for `maByte` bit 7. A select bit of 0 takes the bit of the same position from the control byte. A select bit of 1 takes `liveFebe` (bit 6) or `liveFerf` (bit 7), sampled in the pulse cycle.
- R8: A write to a trail entry never changes the byte being presented. If the write lands in the same cycle as the pulse that selects that entry, the old value is presented and the new value appears the next time the entry is selected.
- R9: Host writes to addresses 18 to 31 have no effect on any entry, the control byte or the select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 5 | Host write address |
| hostWdata | input | 8 | Host write data |
| frameStart | input | 1 | One-cycle pulse at the start of each outbound frame |
| liveFebe | input | 1 | Far-end error indication from the receive side |
| liveFerf | input | 1 | Far-end failure indication from the receive side |
| trByte | output | 8 | Trail trace byte for the current frame |
| maByte | output | 8 | Maintenance byte for the current frame |
| mfStart | output | 1 | High while the trail byte comes from entry 0 |

## Verification
The assertions take it for granted that `frameStart` is a clean synchronous level. Consecutive pulses are allowed, and every high cycle counts as one frame. The assertions also take it for granted that host writes are single-cycle strobes, and they treat the live alarm inputs as valid only in a pulse cycle. The stimulus drives every input once per cycle at the falling edge. It draws addresses over the full 5-bit range, so writes outside the decoded space do occur. It leaves random gaps between pulses and sometimes issues back-to-back pulses. It also lines host writes up with the pulse on purpose, so that writes to the entry about to be presented are covered.

// File: rtl/e3tt_pkg.sv
package e3tt_pkg;
  // Strobes passed from the sequence control to the byte datapath
  typedef struct packed {
    logic load;       // capture new output bytes this cycle
    logic markFirst;  // the selected entry opens a multiframe
  } ctrlStrobes_t;
endpackage

// File: rtl/e3tt_ctrl.sv
module e3tt_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  output e3tt_pkg::ctrlStrobes_t  strobes,
  output logic [IDXW-1:0]         selIdx
);
  localparam logic [IDXW-1:0] LastIdx = IDXW'(DEPTH - 1);

  logic [IDXW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
    end else if (frameStart) begin
      idx <= (idx == LastIdx) ? '0 : idx + 1'b1;
    end
  end

  always_comb begin
    strobes.load      = frameStart;
    strobes.markFirst = (idx == '0);
    selIdx            = idx;
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && idx == LastIdx) |=> (idx == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && idx != LastIdx) |=> (idx == $past(idx) + 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(idx));
endmodule

// File: rtl/e3tt_datapath.sv
module e3tt_datapath #(
  parameter int DEPTH = 16,
  parameter int ADDRW = 5,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWe,
  input  logic [ADDRW-1:0]       hostAddr,
  input  logic [7:0]             hostWdata,
  input  logic                   liveFebe,
  input  logic                   liveFerf,
  input  e3tt_pkg::ctrlStrobes_t strobes,
  input  logic [IDXW-1:0]        selIdx,
  output logic [7:0]             trByte,
  output logic [7:0]             maByte,
  output logic                   mfStart
);
  localparam logic [ADDRW-1:0] MaAddr  = ADDRW'(DEPTH);
  localparam logic [ADDRW-1:0] SelAddr = ADDRW'(DEPTH + 1);

  logic [7:0] ttMem [DEPTH];
  logic [7:0] maCtl;
  logic       selFebe;
  logic       selFerf;
  logic [7:0] maNext;

  // One write port per trail entry
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ttMem[g] <= '0;
      end else if (hostWe && hostAddr == ADDRW'(g)) begin
        ttMem[g] <= hostWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maCtl   <= '0;
      selFebe <= 1'b0;
      selFerf <= 1'b0;
    end else if (hostWe) begin
      if (hostAddr == MaAddr) begin
        maCtl <= hostWdata;
      end
      if (hostAddr == SelAddr) begin
        selFebe <= hostWdata[0];
        selFerf <= hostWdata[1];
      end
    end
  end

  always_comb begin
    maNext    = maCtl;
    maNext[6] = selFebe ? liveFebe : maCtl[6];
    maNext[7] = selFerf ? liveFerf : maCtl[7];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trByte  <= '0;
      maByte  <= '0;
      mfStart <= 1'b0;
    end else if (strobes.load) begin
      trByte  <= ttMem[selIdx];
      maByte  <= maNext;
      mfStart <= strobes.markFirst;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(trByte) && $stable(maByte) && $stable(mfStart)));

  assert_first_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && selIdx == '0) |=> mfStart);

  assert_later_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && selIdx != '0) |=> !mfStart);

  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (maByte[5:0] == $past(maCtl[5:0])));

  assert_old_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (trByte == $past(ttMem[selIdx])));
endmodule

// File: rtl/e3_trail_overhead.sv
module e3_trail_overhead #(
  parameter int DEPTH = 16,
  localparam int ADDRW = $clog2(DEPTH + 2),
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic [ADDRW-1:0] hostAddr,
  input  logic [7:0]       hostWdata,
  input  logic             frameStart,
  input  logic             liveFebe,
  input  logic             liveFerf,
  output logic [7:0]       trByte,
  output logic [7:0]       maByte,
  output logic             mfStart
);
  e3tt_pkg::ctrlStrobes_t strobes;
  logic [IDXW-1:0]        selIdx;

  e3tt_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .strobes    (strobes),
    .selIdx     (selIdx)
  );

  e3tt_datapath #(.DEPTH(DEPTH), .ADDRW(ADDRW)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .liveFebe  (liveFebe),
    .liveFerf  (liveFerf),
    .strobes   (strobes),
    .selIdx    (selIdx),
    .trByte    (trByte),
    .maByte    (maByte),
    .mfStart   (mfStart)
  );
endmodule

// File: tb/test_e3_trail_overhead.sv
module test_e3_trail_overhead;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWe = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic       frameStart = 1'b0;
  logic       liveFebe = 1'b0;
  logic       liveFerf = 1'b0;
  logic [7:0] trByte;
  logic [7:0] maByte;
  logic       mfStart;

  e3_trail_overhead i_e3_trail_overhead (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .frameStart(frameStart), .liveFebe(liveFebe),
    .liveFerf(liveFerf), .trByte(trByte), .maByte(maByte), .mfStart(mfStart)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string curTag = "R1";

  // Reference model state
  logic [7:0] mTt [16];
  logic [7:0] mMa = '0;
  logic [1:0] mSel = '0;
  int         mIdx = 0;
  logic [7:0] expTr = '0;
  logic [7:0] expMa = '0;
  logic       expMf = 1'b0;

  function automatic logic [7:0] maModel(logic [7:0] ctl, logic [1:0] sel, logic febe, logic ferf);
    logic [7:0] r;
    r = ctl;
    if (sel[0]) r[6] = febe;
    if (sel[1]) r[7] = ferf;
    return r;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive one cycle, advance the model, check after the edge
  task automatic stepCycle(bit fs, bit we, logic [4:0] addr, logic [7:0] data, bit febe, bit ferf);
    frameStart = fs; hostWe = we; hostAddr = addr; hostWdata = data;
    liveFebe = febe; liveFerf = ferf;
    if (fs) begin
      expTr = mTt[mIdx];
      expMa = maModel(mMa, mSel, febe, ferf);
      expMf = (mIdx == 0);
      mIdx  = (mIdx + 1) % 16;
    end
    if (we) begin
      if (addr < 16) mTt[addr] = data;
      else if (addr == 16) mMa = data;
      else if (addr == 17) mSel = data[1:0];
    end
    @(posedge clk);
    @(negedge clk);
    frameStart = 1'b0; hostWe = 1'b0;
    check(curTag, "trByte", trByte, expTr);
    check(curTag, "maByte", maByte, expMa);
    check(curTag, "mfStart", {7'b0, mfStart}, {7'b0, expMf});
  endtask

  task automatic hostWrite(logic [4:0] addr, logic [7:0] data);
    stepCycle(1'b0, 1'b1, addr, data, 1'b0, 1'b0);
  endtask

  task automatic frame(bit febe, bit ferf);
    stepCycle(1'b1, 1'b0, 5'd0, 8'd0, febe, ferf);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) mTt[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    curTag = "R1";
    check("R1", "trByte reset", trByte, 8'h00);
    check("R1", "maByte reset", maByte, 8'h00);
    check("R1", "mfStart reset", {7'b0, mfStart}, 8'h00);

    // R4: fill entries, entry 5 deliberately carries a top bit of 1
    curTag = "R4";
    hostWrite(5'd0, 8'hA5);
    for (int i = 1; i < 16; i++) hostWrite(5'(i), 8'(8'h40 + i));
    hostWrite(5'd5, 8'hC3);
    hostWrite(5'd16, 8'h2D);
    hostWrite(5'd17, 8'h00);

    // R1: first frame after reset presents entry 0
    curTag = "R1";
    frame(1'b0, 1'b0);
    // R2/R5: walk the full multiframe and past the wrap, back to back
    curTag = "R2";
    for (int i = 0; i < 17; i++) frame(1'b1, 1'b1);
    // R3: idle cycles hold the outputs
    curTag = "R3";
    for (int i = 0; i < 5; i++) stepCycle(1'b0, 1'b0, 5'd0, 8'd0, 1'b1, 1'b1);

    // R8: overwrite the entry on display, and the entry selected in the same cycle
    curTag = "R8";
    hostWrite(5'((mIdx + 15) % 16), 8'h11);
    stepCycle(1'b1, 1'b1, 5'(mIdx), 8'h22, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) frame(1'b0, 1'b0);

    // R6: low maintenance bits follow the control byte
    curTag = "R6";
    hostWrite(5'd16, 8'h3F); frame(1'b0, 1'b0);
    hostWrite(5'd16, 8'h15); frame(1'b0, 1'b0);

    // R7: each select bit on its own and both together
    curTag = "R7";
    hostWrite(5'd16, 8'h80);
    hostWrite(5'd17, 8'h01); frame(1'b1, 1'b0); frame(1'b0, 1'b1);
    hostWrite(5'd17, 8'h02); frame(1'b1, 1'b0); frame(1'b0, 1'b0);
    hostWrite(5'd17, 8'h03); frame(1'b1, 1'b1); frame(1'b0, 1'b0);
    hostWrite(5'd17, 8'h00); frame(1'b1, 1'b1);

    // R9: out-of-range writes change nothing visible over a full multiframe
    curTag = "R9";
    for (int a = 18; a < 32; a++) hostWrite(5'(a), 8'hFF);
    for (int i = 0; i < 16; i++) frame(1'b1, 1'b1);

    // R2: constrained random mix of pulses, gaps and writes
    curTag = "R2";
    for (int n = 0; n < 1500; n++) begin
      bit fs = ($urandom % 3) == 0;
      bit we = ($urandom % 2) == 0;
      logic [4:0] ad = 5'($urandom);
      stepCycle(fs, we, ad, 8'($urandom), 1'($urandom), 1'($urandom));
    end

    finishRun();
  end
endmodule